// File: doc/BRIEF.md
# Parallel Offset Register Write Sequencer

This block loads the almost-empty and almost-full threshold offsets of a FIFO from the FIFO's own parallel write port, in the write clock domain. A write is steered by two active-low controls. With the load select low and the write enable low, the bus word goes into the offset registers. With the load select high and the write enable low, the word is routed to FIFO memory instead.

When the bus is narrower than an offset, each offset is split into `ceil(OFS_W/BUS_W)` slices. A single rotating pointer walks through every slice of the empty offset, from least to most significant, then through every slice of the full offset, and then wraps. Programming may be paused at any slice and resumed later; the pointer keeps its place. Each offset carries a completion bit. That bit becomes a flag-valid output after two edges of the flag's own clock: the write clock for almost-full and the read clock for almost-empty.

Top module: `ofs_wr_seq`

## Requirements
- R1: On a rising `wclk` edge with `ld_n`=0 and `wen_n`=0, the bus word is stored into the offset slice selected by `slice_ptr`. Slice k of an offset holds offset bits [k*BUS_W +: BUS_W].
- R2: Each offset takes `ceil(OFS_W/BUS_W)` slices. `slice_ptr` value p addresses empty-offset slice p for p < SLICES, and full-offset slice p-SLICES otherwise. It advances by one per offset write and wraps from 2*SLICES-1 to 0. Bus bits that fall above bit OFS_W-1 in the last slice are dropped.
- R3: With `ld_n`=0 and `wen_n`=1, neither offset changes and `slice_ptr` holds, whatever the data bus carries.
- R4: `fifo_wr` is 1 exactly when `ld_n`=1 and `wen_n`=0. Such cycles leave both offsets and `slice_ptr` unchanged, so the next offset write lands on the following slice in sequence.
- R5: While `rst_n` is low, `slice_ptr`, both offsets, `paf_valid` and `pae_valid` are 0; `slice_ptr`=0 addresses the empty offset's lowest slice.
- R6: Writing a slice that is not the last one of an offset clears that offset's completion bit. Writing its last slice sets it. The other offset's completion bit is not affected.
- R7: `paf_valid` equals the full-offset completion bit as it was two `wclk` edges earlier.
- R8: `pae_valid` is the empty-offset completion bit passed through two `rclk` flip-flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock (almost-empty valid domain) |
| rst_n | input | 1 | Asynchronous active-low master reset |
| ld_n | input | 1 | Active-low offset load select |
| wen_n | input | 1 | Active-low write enable |
| din | input | BUS_W | Parallel write data |
| fifo_wr | output | 1 | Write strobe routed to FIFO memory |
| slice_ptr | output | PTR_W | Current offset slice pointer |
| empty_ofs | output | OFS_W | Almost-empty offset value |
| full_ofs | output | OFS_W | Almost-full offset value |
| paf_valid | output | 1 | Almost-full offset valid (wclk domain) |
| pae_valid | output | 1 | Almost-empty offset valid (rclk domain) |

## Verification
The cycle that writes the full offset's last slice also wraps the pointer. If the next cycle writes the empty offset's lowest slice, one completion bit rises while the other is cleared, and the rising bit is still inside its two-stage delay. Directed back-to-back writes and a long random mix of offset writes, memory writes and idle cycles produce this overlap on three widths: two slices per offset, three slices per offset, and a bus wider than the offset. On every write clock, pointer, offsets, routing strobe and both valid outputs are compared against a behavioural model.

// File: rtl/ofs_seq_pkg.sv
package ofs_seq_pkg;

  typedef enum logic [1:0] {
    RT_IDLE   = 2'd0,
    RT_OFFSET = 2'd1,
    RT_MEMORY = 2'd2
  } route_e;

  function automatic route_e route_of(input logic ld_n, input logic wen_n);
    if (wen_n)     return RT_IDLE;
    else if (ld_n) return RT_MEMORY;
    else           return RT_OFFSET;
  endfunction

endpackage

// File: rtl/ofs_rst_sync.sv
module ofs_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/ofs_slice_ptr.sv
module ofs_slice_ptr #(
  parameter int SLICES = 2,
  parameter int PTR_W  = 2,
  parameter int SIDX_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [PTR_W-1:0]  ptr,
  output logic              sel_full,
  output logic [SIDX_W-1:0] slice_idx,
  output logic              last_slice
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(2 * SLICES - 1);
  localparam logic [PTR_W-1:0] HALF = PTR_W'(SLICES);
  localparam logic [PTR_W-1:0] ONE  = PTR_W'(1);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;
  logic [PTR_W-1:0] local_idx;

  always_comb begin
    ptr_d = ptr_q;
    if (adv) ptr_d = (ptr_q == LAST) ? '0 : ptr_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  always_comb begin
    sel_full   = (ptr_q >= HALF);
    local_idx  = sel_full ? (ptr_q - HALF) : ptr_q;
    last_slice = (local_idx == HALF - ONE);
  end

  assign slice_idx = SIDX_W'(local_idx);
  assign ptr       = ptr_q;

endmodule

// File: rtl/ofs_store.sv
module ofs_store #(
  parameter int BUS_W  = 8,
  parameter int OFS_W  = 14,
  parameter int SLICES = 2,
  parameter int SIDX_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              sel_full,
  input  logic [SIDX_W-1:0] slice_idx,
  input  logic              last_slice,
  input  logic [BUS_W-1:0]  din,
  output logic [OFS_W-1:0]  empty_ofs,
  output logic [OFS_W-1:0]  full_ofs,
  output logic              empty_done,
  output logic              full_done
);

  logic [SLICES-1:0] e_wr;
  logic [SLICES-1:0] f_wr;

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    localparam int LO = s * BUS_W;
    localparam int W  = (OFS_W - LO < BUS_W) ? (OFS_W - LO) : BUS_W;

    logic [W-1:0] e_q;
    logic [W-1:0] f_q;

    assign e_wr[s] = we && !sel_full && (slice_idx == SIDX_W'(s));
    assign f_wr[s] = we &&  sel_full && (slice_idx == SIDX_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       e_q <= '0;
      else if (e_wr[s]) e_q <= din[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       f_q <= '0;
      else if (f_wr[s]) f_q <= din[W-1:0];
    end

    assign empty_ofs[LO +: W] = e_q;
    assign full_ofs[LO +: W]  = f_q;
  end

  logic e_done_q, e_done_d;
  logic f_done_q, f_done_d;

  always_comb begin
    e_done_d = e_done_q;
    f_done_d = f_done_q;
    if (we) begin
      if (sel_full) f_done_d = last_slice;
      else          e_done_d = last_slice;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_done_q <= 1'b0;
      f_done_q <= 1'b0;
    end else begin
      e_done_q <= e_done_d;
      f_done_q <= f_done_d;
    end
  end

  assign empty_done = e_done_q;
  assign full_done  = f_done_q;

endmodule

// File: rtl/ofs_flag_pipe.sv
module ofs_flag_pipe #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  if (STAGES == 1) begin : g_one
    always_comb sh_d = d;
  end else begin : g_many
    always_comb sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];

endmodule

// File: rtl/ofs_wr_seq.sv
module ofs_wr_seq #(
  parameter int BUS_W  = 8,
  parameter int OFS_W  = 14,
  parameter int SLICES = (OFS_W + BUS_W - 1) / BUS_W,
  parameter int PTR_W  = $clog2(2 * SLICES),
  parameter int SIDX_W = (SLICES > 1) ? $clog2(SLICES) : 1
) (
  input  logic             wclk,
  input  logic             rclk,
  input  logic             rst_n,
  input  logic             ld_n,
  input  logic             wen_n,
  input  logic [BUS_W-1:0] din,
  output logic             fifo_wr,
  output logic [PTR_W-1:0] slice_ptr,
  output logic [OFS_W-1:0] empty_ofs,
  output logic [OFS_W-1:0] full_ofs,
  output logic             paf_valid,
  output logic             pae_valid
);

  import ofs_seq_pkg::*;

  localparam int FLAG_STAGES = 2;

  logic              wrst_n;
  logic              rrst_n;
  route_e            route;
  logic              ofs_we;
  logic              sel_full;
  logic [SIDX_W-1:0] slice_idx;
  logic              last_slice;
  logic              empty_done;
  logic              full_done;

  ofs_rst_sync u_wrst (.clk(wclk), .arst_n(rst_n), .srst_n(wrst_n));
  ofs_rst_sync u_rrst (.clk(rclk), .arst_n(rst_n), .srst_n(rrst_n));

  always_comb begin
    route   = route_of(ld_n, wen_n);
    ofs_we  = (route == RT_OFFSET);
    fifo_wr = (route == RT_MEMORY);
  end

  ofs_slice_ptr #(
    .SLICES(SLICES), .PTR_W(PTR_W), .SIDX_W(SIDX_W)
  ) u_ptr (
    .clk(wclk), .rst_n(wrst_n), .adv(ofs_we), .ptr(slice_ptr),
    .sel_full(sel_full), .slice_idx(slice_idx), .last_slice(last_slice)
  );

  ofs_store #(
    .BUS_W(BUS_W), .OFS_W(OFS_W), .SLICES(SLICES), .SIDX_W(SIDX_W)
  ) u_store (
    .clk(wclk), .rst_n(wrst_n), .we(ofs_we), .sel_full(sel_full),
    .slice_idx(slice_idx), .last_slice(last_slice), .din(din),
    .empty_ofs(empty_ofs), .full_ofs(full_ofs),
    .empty_done(empty_done), .full_done(full_done)
  );

  ofs_flag_pipe #(.STAGES(FLAG_STAGES)) u_paf (
    .clk(wclk), .rst_n(wrst_n), .d(full_done), .q(paf_valid)
  );

  ofs_flag_pipe #(.STAGES(FLAG_STAGES)) u_pae (
    .clk(rclk), .rst_n(rrst_n), .d(empty_done), .q(pae_valid)
  );

endmodule

// File: rtl/ofs_wr_seq_chk.sv
module ofs_wr_seq_chk #(
  parameter int SLICES = 2,
  parameter int PTR_W  = 2,
  parameter int OFS_W  = 14
) (
  input logic             wclk,
  input logic             wrst_n,
  input logic             fifo_wr,
  input logic             ofs_we,
  input logic             sel_full,
  input logic             last_slice,
  input logic [PTR_W-1:0] slice_ptr,
  input logic [OFS_W-1:0] empty_ofs,
  input logic [OFS_W-1:0] full_ofs,
  input logic             empty_done,
  input logic             full_done,
  input logic             paf_valid
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(2 * SLICES - 1);

  assert_ptr_range_R2: assert property (@(posedge wclk) disable iff (!wrst_n)
    slice_ptr <= LAST);

  assert_ptr_step_R2: assert property (@(posedge wclk) disable iff (!wrst_n)
    ofs_we |=> slice_ptr == (($past(slice_ptr) == LAST) ? '0
                              : $past(slice_ptr) + PTR_W'(1)));

  assert_ptr_hold_R3: assert property (@(posedge wclk) disable iff (!wrst_n)
    !ofs_we |=> $stable(slice_ptr));

  assert_route_excl_R4: assert property (@(posedge wclk) disable iff (!wrst_n)
    $onehot0({fifo_wr, ofs_we}));

  assert_mem_keeps_ofs_R4: assert property (@(posedge wclk) disable iff (!wrst_n)
    fifo_wr |=> $stable(empty_ofs) && $stable(full_ofs));

  assert_done_clear_R6: assert property (@(posedge wclk) disable iff (!wrst_n)
    (ofs_we && !sel_full && !last_slice) |=> !empty_done && $stable(full_done));

  assert_paf_delay_R7: assert property (@(posedge wclk) disable iff (!wrst_n)
    paf_valid == $past(full_done, 2));

endmodule

bind ofs_wr_seq ofs_wr_seq_chk #(
  .SLICES(SLICES), .PTR_W(PTR_W), .OFS_W(OFS_W)
) u_chk (
  .wclk(wclk), .wrst_n(wrst_n), .fifo_wr(fifo_wr), .ofs_we(ofs_we),
  .sel_full(sel_full), .last_slice(last_slice), .slice_ptr(slice_ptr),
  .empty_ofs(empty_ofs), .full_ofs(full_ofs), .empty_done(empty_done),
  .full_done(full_done), .paf_valid(paf_valid)
);

// File: tb/ofs_wr_seq_tb.sv
`timescale 1ns/100ps
module ofs_wr_seq_tb;

  localparam int OW = 14;

  logic        wclk, rclk, rst_n, ld_n, wen_n;
  logic [15:0] din;

  logic        fw0, fw1, fw2, pf0, pf1, pf2, pe0, pe1, pe2;
  logic [1:0]  p0;
  logic [2:0]  p1;
  logic [0:0]  p2;
  logic [OW-1:0] e0, e1, e2, f0, f1, f2;

  ofs_wr_seq #(.BUS_W(8), .OFS_W(OW)) u_dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .ld_n(ld_n), .wen_n(wen_n),
    .din(din[7:0]), .fifo_wr(fw0), .slice_ptr(p0), .empty_ofs(e0),
    .full_ofs(f0), .paf_valid(pf0), .pae_valid(pe0));

  ofs_wr_seq #(.BUS_W(6), .OFS_W(OW)) u_dut3 (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .ld_n(ld_n), .wen_n(wen_n),
    .din(din[5:0]), .fifo_wr(fw1), .slice_ptr(p1), .empty_ofs(e1),
    .full_ofs(f1), .paf_valid(pf1), .pae_valid(pe1));

  ofs_wr_seq #(.BUS_W(16), .OFS_W(OW)) u_dut1 (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .ld_n(ld_n), .wen_n(wen_n),
    .din(din), .fifo_wr(fw2), .slice_ptr(p2), .empty_ofs(e2),
    .full_ofs(f2), .paf_valid(pf2), .pae_valid(pe2));

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h @%0t", tag, what, act, exp, $time);
    end
  endtask

  initial begin wclk = 0; forever #2 wclk = ~wclk; end
  initial begin rclk = 0; #1; forever #3.5 rclk = ~rclk; end

  // behavioural reference: per variant slice count and bus width
  int        nsl [3] = '{2, 3, 1};
  int        bw  [3] = '{8, 6, 16};
  int        m_ptr [3];
  bit [OW-1:0] m_e [3], m_f [3];
  bit        m_ed [3], m_fd [3], m_f1 [3], m_f2 [3], m_e1 [3], m_e2 [3];

  always @(posedge wclk) begin
    for (int v = 0; v < 3; v++) begin
      if (!rst_n) begin
        m_ptr[v] = 0; m_e[v] = '0; m_f[v] = '0;
        m_ed[v] = 0; m_fd[v] = 0; m_f1[v] = 0; m_f2[v] = 0;
      end else begin
        m_f2[v] = m_f1[v];
        m_f1[v] = m_fd[v];
        if (!ld_n && !wen_n) begin
          bit full_t;
          int s;
          full_t = (m_ptr[v] >= nsl[v]);
          s = full_t ? m_ptr[v] - nsl[v] : m_ptr[v];
          for (int b = 0; b < bw[v]; b++) begin
            int pos;
            pos = s * bw[v] + b;
            if (pos < OW) begin
              if (full_t) m_f[v][pos] = din[b];
              else        m_e[v][pos] = din[b];
            end
          end
          if (full_t) m_fd[v] = (s == nsl[v] - 1);
          else        m_ed[v] = (s == nsl[v] - 1);
          m_ptr[v] = (m_ptr[v] == 2 * nsl[v] - 1) ? 0 : m_ptr[v] + 1;
        end
      end
    end
    #1;
    chk("R4", "fifo_wr/0", fw0, ld_n & ~wen_n);
    chk("R4", "fifo_wr/1", fw1, ld_n & ~wen_n);
    chk("R4", "fifo_wr/2", fw2, ld_n & ~wen_n);
    chk("R2", "ptr/0", p0, m_ptr[0]);
    chk("R2", "ptr/1", p1, m_ptr[1]);
    chk("R2", "ptr/2", p2, m_ptr[2]);
    chk("R1", "empty/0", e0, m_e[0]);
    chk("R1", "empty/1", e1, m_e[1]);
    chk("R1", "empty/2", e2, m_e[2]);
    chk("R1", "full/0", f0, m_f[0]);
    chk("R1", "full/1", f1, m_f[1]);
    chk("R1", "full/2", f2, m_f[2]);
    chk("R7", "paf/0", pf0, m_f2[0]);
    chk("R7", "paf/1", pf1, m_f2[1]);
    chk("R7", "paf/2", pf2, m_f2[2]);
    chk("R8", "pae/0", pe0, m_e2[0]);
    chk("R8", "pae/1", pe1, m_e2[1]);
    chk("R8", "pae/2", pe2, m_e2[2]);
  end

  always @(posedge rclk or negedge rst_n) begin
    for (int v = 0; v < 3; v++) begin
      if (!rst_n) begin m_e1[v] = 0; m_e2[v] = 0; end
      else begin m_e2[v] = m_e1[v]; m_e1[v] = m_ed[v]; end
    end
  end

  task automatic cyc(input bit l, input bit w, input logic [15:0] d);
    @(negedge wclk);
    ld_n = l; wen_n = w; din = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b1, 16'h0);
  endtask

  task automatic rand_phase(input int n);
    for (int i = 0; i < n; i++)
      cyc(($urandom % 4) == 0, ($urandom % 3) == 0, 16'($urandom));
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [1:0]    hold_p;
    logic [OW-1:0] hold_e, hold_f;
    rst_n = 0; ld_n = 1; wen_n = 1; din = '0;
    repeat (3) @(negedge wclk);
    // R5: state held clear during reset
    chk("R5", "ptr in reset", p0, 0);
    chk("R5", "empty in reset", e0, 0);
    chk("R5", "full in reset", f0, 0);
    chk("R5", "pae in reset", pe0, 0);
    rst_n = 1;
    idle(6);

    // R1/R2 full two-slice pass, then settle: both flags valid (R6)
    cyc(0, 0, 16'hA5C3); cyc(0, 0, 16'h3C7E);
    cyc(0, 0, 16'h1234); cyc(0, 0, 16'hFFFF);
    idle(6);
    @(negedge wclk);
    chk("R6", "pae after both", pe0, 1);
    chk("R6", "paf after both", pf0, 1);
    chk("R1", "empty value", e0, 14'h3EC3);
    chk("R1", "full value", f0, 14'h3F34);

    // R6: rewrite empty low slice only
    cyc(0, 0, 16'h005A);
    idle(6);
    @(negedge wclk);
    chk("R6", "pae cleared", pe0, 0);
    chk("R6", "paf untouched", pf0, 1);
    chk("R1", "empty low slice", e0[7:0], 8'h5A);

    // R3: load low, enable high
    hold_p = p0; hold_e = e0; hold_f = f0;
    cyc(0, 1, 16'hFFFF); cyc(0, 1, 16'h1111); cyc(0, 1, 16'h7777);
    @(negedge wclk);
    chk("R3", "ptr held", p0, hold_p);
    chk("R3", "empty held", e0, hold_e);
    chk("R3", "full held", f0, hold_f);

    // R4: memory writes, then resume at next slice
    cyc(1, 0, 16'hBEEF); cyc(1, 0, 16'hCAFE); cyc(1, 0, 16'h0F0F);
    @(negedge wclk);
    chk("R4", "ptr after mem", p0, hold_p);
    chk("R4", "empty after mem", e0, hold_e);
    cyc(0, 0, 16'h0027);
    idle(1);
    @(negedge wclk);
    chk("R4", "resume empty msb", e0[13:8], 6'h27);
    chk("R4", "resume ptr", p0, 2);

    rand_phase(400);

    // R5: reset mid-run
    @(negedge wclk);
    rst_n = 0; ld_n = 1; wen_n = 1;
    #1;
    chk("R5", "ptr reset", p0, 0);
    chk("R5", "ptr3 reset", p1, 0);
    chk("R5", "empty reset", e1, 0);
    chk("R5", "paf reset", pf0, 0);
    chk("R5", "pae reset", pe1, 0);
    repeat (2) @(negedge wclk);
    rst_n = 1;
    idle(6);
    rand_phase(300);
    idle(8);
    finish_run();
  end

endmodule